// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block runs the service sweep for a pair of cascaded four-channel DMA controllers, one that moves bytes and one that moves 16-bit words. A sweep starts on a single-cycle start pulse. It then examines the eight system channels one per cycle, in ascending order. Every channel that is eligible is granted to a transfer engine through a request/acknowledge handshake. A channel is eligible when its controller is enabled, its mask bit is clear and its request bit is set. When the engine acknowledges, the block writes back the channel's updated current count. A done pulse closes the sweep after the last channel has been examined.

Positions handed to the engine are in bytes. On the word controller the stored counts are shifted left by one on the way out, and the returned end position is shifted right by one on the way back. A returned end position below the offered start marks an auto-init wrap. The block also keeps the eight request bits, which are set and cleared by per-channel hardware pulses.

Top module: `dma_service_sched`

## Requirements
- R1: After reset no grant, write-back or done pulse is active and all request bits read 0.
- R2: Channels are examined in ascending system order 0 to 7, where the system number is controller × 4 + index; channels 0-3 belong to controller 0 and 4-7 to controller 1.
- R3: While bit c of `ctl_disable_i` is 1, no channel of controller c is granted.
- R4: A channel is granted only when its bit in `mask_i` is 0 and its request bit is 1, and each eligible channel is granted exactly once per sweep.
- R5: During a grant, `xfer_start_o` equals the current count shifted left by s, and `xfer_len_o` equals (base count + 1) shifted left by s, where s is 1 for channels 4-7 and 0 for channels 0-3.
- R6: One cycle after an acknowledge, `wb_valid_o` pulses for one cycle with the granted channel and with a count equal to `xfer_end_i` shifted right by s.
- R7: `wb_wrap_o` is 1 exactly when the returned end position is lower than the offered start.
- R8: During a grant, the channel's mode byte is presented, and three fields are decoded from it: bits 7:6 give the operating mode, bit 5 selects decrement and bit 4 selects auto-init.
- R9: A pulse on `req_set_i[n]` sets request bit n, and a pulse on `req_clr_i[n]` clears it; when both pulse together, set wins.
- R10: At most one channel is granted at a time, and the granted channel, start and length hold steady until acknowledged.
- R11: `done_o` pulses for one cycle after channel 7 has been examined. A sweep with no eligible channel raises it 8 cycles after the start pulse is taken. A start pulse during a sweep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start_i | input | 1 | Begin a sweep (taken only when idle) |
| ctl_disable_i | input | 2 | Per-controller disable, bit c for controller c |
| mask_i | input | 8 | Per-channel mask, 1 blocks service |
| req_set_i | input | 8 | Per-channel hardware request set pulse |
| req_clr_i | input | 8 | Per-channel hardware request clear pulse |
| base_count_i | input | 128 | Base counts, channel n at bits 16n+15:16n |
| cur_count_i | input | 128 | Current counts, channel n at bits 16n+15:16n |
| mode_i | input | 64 | Mode bytes, channel n at bits 8n+7:8n |
| xfer_req_o | output | 1 | Grant to the transfer engine |
| xfer_chan_o | output | 3 | Granted system channel |
| xfer_start_o | output | 18 | Start position in bytes |
| xfer_len_o | output | 18 | Total length in bytes |
| xfer_mode_o | output | 8 | Mode byte of the granted channel |
| xfer_opmode_o | output | 2 | Operating mode field |
| xfer_dec_o | output | 1 | Decrement select |
| xfer_autoinit_o | output | 1 | Auto-init select |
| xfer_ack_i | input | 1 | Engine finished, end position valid |
| xfer_end_i | input | 18 | Returned end position in bytes |
| wb_valid_o | output | 1 | Current-count write-back strobe |
| wb_chan_o | output | 3 | Channel being written back |
| wb_count_o | output | 16 | New current count |
| wb_wrap_o | output | 1 | End position fell below start |
| req_o | output | 8 | Request bits |
| done_o | output | 1 | Sweep finished |

## Verification
The bench targets the eligibility corners. When one controller is disabled, a design that ignored the disable bit would grant channels it must skip. With masks and requests in interleaved patterns, a design with a swapped polarity or a wrong bit index grants the complement of the expected set. On the word controller, start, length and write-back counts are checked, because a design that skipped the shift or applied it on the wrong controller would return counts off by a factor of two. A zero end position forces a wrap. The bench also checks an empty sweep for exact done timing, a start pulse sent mid-sweep that must not restart the sweep, and a simultaneous set and clear of a request bit.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
    localparam int unsigned CNT_W      = 16;
    localparam int unsigned MODE_W     = 8;
    localparam int unsigned CH_PER_CTL = 4;
    localparam int unsigned NUM_CTL    = 2;
    localparam int unsigned NUM_CH     = CH_PER_CTL * NUM_CTL;
    localparam int unsigned PTR_W      = $clog2(NUM_CH);
    localparam int unsigned IDX_W      = $clog2(CH_PER_CTL);
    localparam int unsigned POS_W      = CNT_W + 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_GRANT = 2'd2
    } sched_st_e;

    typedef struct packed {
        sched_st_e               st;
        logic [PTR_W-1:0]        ptr;
        logic [POS_W-1:0]        start;
        logic [POS_W-1:0]        len;
        logic [MODE_W-1:0]       mode;
        logic                    wb_valid;
        logic [PTR_W-1:0]        wb_chan;
        logic [CNT_W-1:0]        wb_count;
        logic                    wb_wrap;
        logic                    done;
    } sched_s;

    // Channels past the first controller move words: positions scale by 2.
    function automatic logic word_ctl(input logic [PTR_W-1:0] ch);
        return ch >= PTR_W'(CH_PER_CTL);
    endfunction
endpackage

// File: rtl/dma_req_bank.sv
module dma_req_bank
    import dma_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] req_o
);
    logic [NUM_CH-1:0] req_d, req_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
        always_comb begin
            req_d[g] = req_q[g];
            if (clr_i[g]) req_d[g] = 1'b0;
            if (set_i[g]) req_d[g] = 1'b1;
        end

        assert_req_set_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> req_q[g]);
        assert_req_clr_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !req_q[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/dma_chan_view.sv
module dma_chan_view
    import dma_sched_pkg::*;
(
    input  logic [PTR_W-1:0]         ptr_i,
    input  logic [NUM_CTL-1:0]       ctl_disable_i,
    input  logic [NUM_CH-1:0]        mask_i,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH*CNT_W-1:0]  base_flat_i,
    input  logic [NUM_CH*CNT_W-1:0]  cur_flat_i,
    input  logic [NUM_CH*MODE_W-1:0] mode_flat_i,
    output logic                     elig_o,
    output logic [POS_W-1:0]         start_o,
    output logic [POS_W-1:0]         len_o,
    output logic [MODE_W-1:0]        mode_o
);
    logic [CNT_W-1:0]  base_arr [NUM_CH];
    logic [CNT_W-1:0]  cur_arr  [NUM_CH];
    logic [MODE_W-1:0] mode_arr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign base_arr[g] = base_flat_i[g*CNT_W +: CNT_W];
        assign cur_arr[g]  = cur_flat_i[g*CNT_W +: CNT_W];
        assign mode_arr[g] = mode_flat_i[g*MODE_W +: MODE_W];
    end

    logic [PTR_W-IDX_W-1:0] ctl_sel;
    logic                   shift;

    always_comb begin
        ctl_sel = ptr_i[PTR_W-1:IDX_W];
        shift   = word_ctl(ptr_i);
        elig_o  = !ctl_disable_i[ctl_sel] && !mask_i[ptr_i] && req_i[ptr_i];
        start_o = POS_W'(cur_arr[ptr_i]) << shift;
        len_o   = (POS_W'(base_arr[ptr_i]) + POS_W'(1)) << shift;
        mode_o  = mode_arr[ptr_i];
    end
endmodule

// File: rtl/dma_service_sched.sv
module dma_service_sched
    import dma_sched_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scan_start_i,
    input  logic [NUM_CTL-1:0]       ctl_disable_i,
    input  logic [NUM_CH-1:0]        mask_i,
    input  logic [NUM_CH-1:0]        req_set_i,
    input  logic [NUM_CH-1:0]        req_clr_i,
    input  logic [NUM_CH*CNT_W-1:0]  base_count_i,
    input  logic [NUM_CH*CNT_W-1:0]  cur_count_i,
    input  logic [NUM_CH*MODE_W-1:0] mode_i,
    output logic                     xfer_req_o,
    output logic [PTR_W-1:0]         xfer_chan_o,
    output logic [POS_W-1:0]         xfer_start_o,
    output logic [POS_W-1:0]         xfer_len_o,
    output logic [MODE_W-1:0]        xfer_mode_o,
    output logic [1:0]               xfer_opmode_o,
    output logic                     xfer_dec_o,
    output logic                     xfer_autoinit_o,
    input  logic                     xfer_ack_i,
    input  logic [POS_W-1:0]         xfer_end_i,
    output logic                     wb_valid_o,
    output logic [PTR_W-1:0]         wb_chan_o,
    output logic [CNT_W-1:0]         wb_count_o,
    output logic                     wb_wrap_o,
    output logic [NUM_CH-1:0]        req_o,
    output logic                     done_o
);
    localparam logic [PTR_W-1:0] LAST_CH = PTR_W'(NUM_CH - 1);

    logic [NUM_CH-1:0] req_bits;
    logic              view_elig;
    logic [POS_W-1:0]  view_start, view_len;
    logic [MODE_W-1:0] view_mode;
    logic [POS_W-1:0]  end_scaled;
    sched_s            d, q;

    dma_req_bank u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (req_set_i),
        .clr_i (req_clr_i),
        .req_o (req_bits)
    );

    dma_chan_view u_view (
        .ptr_i         (q.ptr),
        .ctl_disable_i (ctl_disable_i),
        .mask_i        (mask_i),
        .req_i         (req_bits),
        .base_flat_i   (base_count_i),
        .cur_flat_i    (cur_count_i),
        .mode_flat_i   (mode_i),
        .elig_o        (view_elig),
        .start_o       (view_start),
        .len_o         (view_len),
        .mode_o        (view_mode)
    );

    always_comb begin
        d          = q;
        d.wb_valid = 1'b0;
        d.done     = 1'b0;
        end_scaled = xfer_end_i >> word_ctl(q.ptr);
        unique case (q.st)
            ST_IDLE: begin
                if (scan_start_i) begin
                    d.st  = ST_SCAN;
                    d.ptr = '0;
                end
            end
            ST_SCAN: begin
                if (view_elig) begin
                    d.st    = ST_GRANT;
                    d.start = view_start;
                    d.len   = view_len;
                    d.mode  = view_mode;
                end else if (q.ptr == LAST_CH) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.ptr = q.ptr + PTR_W'(1);
                end
            end
            ST_GRANT: begin
                if (xfer_ack_i) begin
                    d.wb_valid = 1'b1;
                    d.wb_chan  = q.ptr;
                    d.wb_count = end_scaled[CNT_W-1:0];
                    d.wb_wrap  = xfer_end_i < q.start;
                    if (q.ptr == LAST_CH) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st  = ST_SCAN;
                        d.ptr = q.ptr + PTR_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign xfer_req_o      = (q.st == ST_GRANT);
    assign xfer_chan_o     = q.ptr;
    assign xfer_start_o    = q.start;
    assign xfer_len_o      = q.len;
    assign xfer_mode_o     = q.mode;
    assign xfer_opmode_o   = q.mode[7:6];
    assign xfer_dec_o      = q.mode[5];
    assign xfer_autoinit_o = q.mode[4];
    assign wb_valid_o      = q.wb_valid;
    assign wb_chan_o       = q.wb_chan;
    assign wb_count_o      = q.wb_count;
    assign wb_wrap_o       = q.wb_wrap;
    assign req_o           = req_bits;
    assign done_o          = q.done;

    // R3: a grant never begins on a channel of a disabled controller.
    assert_disabled_ctl_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req_o) |-> !$past(ctl_disable_i[xfer_chan_o[PTR_W-1:IDX_W]]));
    // R4: a grant begins only on an unmasked, requesting channel.
    assert_grant_eligible_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req_o) |-> $past(req_bits[xfer_chan_o] && !mask_i[xfer_chan_o]));
    // R10: an outstanding grant keeps its channel and positions.
    assert_grant_stable_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_chan_o)
                                         && $stable(xfer_start_o) && $stable(xfer_len_o)));
    // R6: a write-back follows an acknowledged grant and lasts one cycle.
    assert_wb_after_ack_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> $past(xfer_req_o && xfer_ack_i));
    assert_wb_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |=> !wb_valid_o);
    // R11: done is a single-cycle pulse.
    assert_done_pulse_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/dma_service_sched_tb.sv
module dma_service_sched_tb_top;
    import dma_sched_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     scan_start = 1'b0;
    logic [NUM_CTL-1:0]       ctl_dis = '0;
    logic [NUM_CH-1:0]        mask = '0;
    logic [NUM_CH-1:0]        rset = '0;
    logic [NUM_CH-1:0]        rclr = '0;
    logic [NUM_CH*CNT_W-1:0]  base_flat;
    logic [NUM_CH*CNT_W-1:0]  cur_flat;
    logic [NUM_CH*MODE_W-1:0] mode_flat;
    logic                     xfer_req, xfer_dec, xfer_ai, ack = 1'b0;
    logic [PTR_W-1:0]         xfer_chan, wb_chan;
    logic [POS_W-1:0]         xfer_start, xfer_len, xfer_end = '0;
    logic [MODE_W-1:0]        xfer_mode;
    logic [1:0]               xfer_opm;
    logic                     wb_valid, wb_wrap, done;
    logic [CNT_W-1:0]         wb_count;
    logic [NUM_CH-1:0]        req_bits;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_service_sched dut_i (
        .clk (clk), .rst_n (rst_n), .scan_start_i (scan_start),
        .ctl_disable_i (ctl_dis), .mask_i (mask),
        .req_set_i (rset), .req_clr_i (rclr),
        .base_count_i (base_flat), .cur_count_i (cur_flat), .mode_i (mode_flat),
        .xfer_req_o (xfer_req), .xfer_chan_o (xfer_chan),
        .xfer_start_o (xfer_start), .xfer_len_o (xfer_len),
        .xfer_mode_o (xfer_mode), .xfer_opmode_o (xfer_opm),
        .xfer_dec_o (xfer_dec), .xfer_autoinit_o (xfer_ai),
        .xfer_ack_i (ack), .xfer_end_i (xfer_end),
        .wb_valid_o (wb_valid), .wb_chan_o (wb_chan), .wb_count_o (wb_count),
        .wb_wrap_o (wb_wrap), .req_o (req_bits), .done_o (done)
    );

    function automatic logic [CNT_W-1:0] cur_of(input int ch);
        return CNT_W'(16'h1000 + ch * 16'h0111);
    endfunction
    function automatic logic [CNT_W-1:0] base_of(input int ch);
        return CNT_W'(16'h2000 + ch * 3);
    endfunction
    function automatic logic [MODE_W-1:0] mode_of(input int ch);
        return MODE_W'(((ch % 4) << 6) | ((ch & 1) << 5) | (((ch >> 1) & 1) << 4) | ch);
    endfunction

    initial begin
        for (int i = 0; i < NUM_CH; i++) begin
            base_flat[i*CNT_W +: CNT_W]   = base_of(i);
            cur_flat[i*CNT_W +: CNT_W]    = cur_of(i);
            mode_flat[i*MODE_W +: MODE_W] = mode_of(i);
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_req(input logic [NUM_CH-1:0] pattern);
        @(negedge clk); rclr = '1; rset = '0;
        @(negedge clk); rclr = '0; rset = pattern;
        @(negedge clk); rset = '0;
        check(req_bits == pattern, "R9 request load", 32'(req_bits), 32'(pattern));
    endtask

    // Runs one sweep, answering every grant; end = start + 6, or 0 on wrap_ch.
    task automatic run_sweep(input logic [NUM_CH-1:0] exp, input int wrap_ch);
        logic [NUM_CH-1:0] served = '0;
        int last = -1;
        int n = 0;
        bit seen = 0;
        @(negedge clk); scan_start = 1'b1;
        @(negedge clk); scan_start = 1'b0;
        while (!seen && n < 100) begin
            if (done) begin
                seen = 1;
            end else if (xfer_req) begin
                int ch = int'(xfer_chan);
                int s = (ch >= 4) ? 1 : 0;
                logic [POS_W-1:0] st_e = POS_W'(cur_of(ch)) << s;
                logic [POS_W-1:0] ln_e = (POS_W'(base_of(ch)) + 1) << s;
                logic [POS_W-1:0] en = (ch == wrap_ch) ? '0 : st_e + 6;
                logic [MODE_W-1:0] m = mode_of(ch);
                check(ch > last, "R2 ascending order", 32'(ch), 32'(last + 1));
                check(exp[ch], "R3/R4 granted channel eligible", 32'(ch), 32'(exp));
                check(xfer_start == st_e, "R5 start position", 32'(xfer_start), 32'(st_e));
                check(xfer_len == ln_e, "R5 length", 32'(xfer_len), 32'(ln_e));
                check({xfer_mode, xfer_opm, xfer_dec, xfer_ai} == {m, m[7:6], m[5], m[4]},
                      "R8 mode fields", 32'({xfer_opm, xfer_dec, xfer_ai}), 32'({m[7:6], m[5], m[4]}));
                ack = 1'b1; xfer_end = en;
                @(negedge clk);
                ack = 1'b0; xfer_end = '0;
                check(wb_valid && wb_chan == PTR_W'(ch), "R6 write-back channel", 32'(wb_chan), 32'(ch));
                check(wb_count == CNT_W'(en >> s), "R6 write-back count", 32'(wb_count), 32'(en >> s));
                check(wb_wrap == (ch == wrap_ch), "R7 wrap flag", 32'(wb_wrap), 32'(ch == wrap_ch));
                check(!xfer_req, "R10 grant released", 32'(xfer_req), 32'(0));
                served[ch] = 1'b1;
                last = ch;
            end else begin
                @(negedge clk);
            end
            n++;
        end
        check(seen, "R11 done reached", 32'(seen), 32'(1));
        check(served == exp, "R4 serviced set", 32'(served), 32'(exp));
        @(negedge clk);
        check(!done, "R11 done single pulse", 32'(done), 32'(0));
    endtask

    // {disable[1:0], mask[7:0], request[7:0]}
    localparam logic [17:0] VECS [7] = '{
        {2'b00, 8'h00, 8'hFF},
        {2'b01, 8'h00, 8'hFF},
        {2'b10, 8'h00, 8'hFF},
        {2'b00, 8'hA5, 8'hFF},
        {2'b00, 8'h00, 8'h3C},
        {2'b11, 8'h00, 8'hFF},
        {2'b00, 8'hF0, 8'h0F}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({xfer_req, wb_valid, done} == 3'b000, "R1 outputs idle", 32'({xfer_req, wb_valid, done}), 32'(0));
        check(req_bits == '0, "R1 requests clear", 32'(req_bits), 32'(0));

        for (int v = 0; v < 7; v++) begin
            logic [1:0] dv = VECS[v][17:16];
            logic [7:0] mv = VECS[v][15:8];
            logic [7:0] rv = VECS[v][7:0];
            logic [7:0] ctl_ok = {{4{!dv[1]}}, {4{!dv[0]}}};
            ctl_dis = dv; mask = mv;
            load_req(rv);
            run_sweep(rv & ~mv & ctl_ok, -1);
        end

        // R7 wrap on a word channel and a byte channel
        ctl_dis = '0; mask = '0;
        load_req(8'h24);
        run_sweep(8'h24, 5);
        run_sweep(8'h24, 2);

        // R11 empty sweep: done exactly 8 cycles after the start is taken
        load_req(8'h00);
        begin
            int k = 0;
            @(negedge clk); scan_start = 1'b1;
            @(negedge clk); scan_start = 1'b0;
            while (!done && k < 20) begin @(negedge clk); k++; end
            check(k == 8, "R11 empty sweep length", 32'(k), 32'(8));
        end

        // R11 start pulse during a sweep is ignored; R10 single grant
        load_req(8'h04);
        begin
            int dones = 0;
            int grants = 0;
            @(negedge clk); scan_start = 1'b1;
            @(negedge clk); scan_start = 1'b0;
            while (!xfer_req) @(negedge clk);
            scan_start = 1'b1;
            @(negedge clk); scan_start = 1'b0;
            ack = 1'b1; xfer_end = '0;
            @(negedge clk); ack = 1'b0;
            for (int c = 0; c < 30; c++) begin
                if (done) dones++;
                if (xfer_req) grants++;
                @(negedge clk);
            end
            check(dones == 1, "R11 busy start ignored", 32'(dones), 32'(1));
            check(grants == 0, "R10 no extra grant", 32'(grants), 32'(0));
        end

        // R9 simultaneous set and clear: set wins; lone clear clears
        @(negedge clk); rset = 8'h81; rclr = 8'h81;
        @(negedge clk); rset = '0; rclr = '0;
        check(req_bits == 8'h85, "R9 set wins", 32'(req_bits), 32'h85);
        @(negedge clk); rclr = 8'h04;
        @(negedge clk); rclr = '0;
        check(req_bits == 8'h81, "R9 clear", 32'(req_bits), 32'h81);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule